// File: doc/BRIEF.md
# Overlap-Aware Block Copy Engine

This block is a hardware state machine that copies a run of bytes forward through memory, from a source byte address to a destination byte address. A single start pulse loads the two pointers and a byte count. The engine then picks a transfer mode in one fixed setup cycle. It moves the data over a simple synchronous 64-bit memory port that has one read channel and one write channel with per-byte enables. When it finishes, it raises a one-cycle done pulse and returns both end pointers.

There are two transfer modes. Chunked mode copies whole 64-bit words, but only when both pointers are 8-byte aligned and the count is at least 8. Every other nonzero copy, including any pair of pointers that overlap closely, falls back to single-byte transfers. The result is then always identical to a plain forward byte-by-byte copy.

Chunked mode has three phases:
- A fixed initial burst of word slots, where slots past the count are suppressed.
- A check of whether the burst covered the whole length. If not, the remaining words follow.
- A closing 8-byte move of the buffer's last eight bytes when the count is not a multiple of 8. This move rewrites bytes that the previous word already copied.

Top module: `blkcpy`

## Requirements
- R1: A start with a count of zero produces a done pulse, performs no memory write, and returns end pointers equal to the input pointers.
- R2: When the destination lies 1 to 7 bytes after the source, the final memory contents equal those of a forward one-byte-at-a-time copy.
- R3: Chunked mode is used exactly when both pointers are 8-byte aligned and the count is at least 8. Each main write in this mode has all eight enables set. The result equals a forward byte copy, even when the buffers overlap at a distance of 8 or more.
- R4: Every other nonzero copy uses byte transfers. Each byte write has exactly one enable set, and no byte outside [dst, dst+count) is ever written. Enable bit l selects byte address word*8+l.
- R5: Chunked mode always spends a fixed burst of BURST_BYTES/8 word slots (12 by default) before checking the length. Slots beyond the count perform no access. As a result, every chunked copy of 8 to 96 bytes with no tail has the same start-to-done latency.
- R6: When the count exceeds the burst, the engine issues further word transfers after the check, one per remaining full word. A 200-byte copy makes 25 writes.
- R7: In chunked mode, a count that is not a multiple of 8 ends with a move of the last 8 bytes of the buffer. This move is issued as two writes:
  - first, the upper 8-e lanes of the last full word;
  - then, the lower e lanes of the following word, where e is count mod 8.
- R8: Reads have one cycle of latency. Every write is preceded in the previous cycle by the read that supplies its data, and at most one read and one write are issued per cycle.
- R9: A start pulse received while busy is ignored. Pointers, count, writes and results stay those of the running copy.
- R10: Busy is high from the cycle after start through the done cycle. Done lasts exactly one cycle. While copying, the remaining-count output shows the count; it is 0 at done and when idle. At done, the end pointers equal the inputs advanced by the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| src_i | input | AW | Source byte address |
| dst_i | input | AW | Destination byte address |
| len_i | input | CW | Byte count |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_end_o | output | AW | Source pointer advanced by the count |
| dst_end_o | output | AW | Destination pointer advanced by the count |
| left_o | output | CW | Remaining count: the count while copying, 0 at done |
| mem_re_o | output | 1 | Read request |
| mem_raddr_o | output | AW-3 | Read word address |
| mem_rdata_i | input | 64 | Read data, valid one cycle after the request |
| mem_we_o | output | 1 | Write request |
| mem_waddr_o | output | AW-3 | Write word address |
| mem_wdata_o | output | 64 | Write data |
| mem_be_o | output | 8 | Write byte enables, bit l is lane l |

## Verification
The assertions assume the following about the environment:
- The memory returns read data exactly one cycle after a request.
- Start is a pulse whose pointer and count inputs are stable in the cycle it is sampled.
- No copied range wraps past the top of the address space.

The bench keeps to these assumptions with a one-cycle memory model, by driving inputs only at falling edges, and by placing every buffer well inside the 4 KiB space. Overlapping, misaligned, short and beyond-burst cases are then chosen inside those limits.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
  typedef enum logic [1:0] {MODE_ZERO, MODE_BYTE, MODE_CHUNK} mode_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_BRD, ST_BWR, ST_CHECK, ST_CRD, ST_CWR,
    ST_TRD, ST_TWR, ST_YRD, ST_YWR, ST_FIN
  } state_e;
  localparam int LANES = 8;
endpackage

// File: rtl/blkcpy_mode_sel.sv
module blkcpy_mode_sel
  import blkcpy_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 12
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] len_i,
  output mode_e         mode_o
);
  logic [AW-1:0] gap;
  logic close_fwd, aligned, long_enough;

  assign gap         = dst_i - src_i;
  assign close_fwd   = (gap != '0) && (gap < AW'(LANES));
  assign aligned     = (src_i[2:0] == 3'd0) && (dst_i[2:0] == 3'd0);
  assign long_enough = len_i >= CW'(LANES);

  always_comb begin
    if (len_i == '0)                              mode_o = MODE_ZERO;
    else if (close_fwd || !aligned || !long_enough) mode_o = MODE_BYTE;
    else                                          mode_o = MODE_CHUNK;
  end
endmodule

// File: rtl/blkcpy_lane.sv
module blkcpy_lane (
  input  logic [63:0] rdata_i,
  input  logic [2:0]  src_lane_i,
  input  logic [2:0]  dst_lane_i,
  input  logic [2:0]  tail_e_i,
  input  logic        tail_hi_i,
  output logic [63:0] byte_wdata_o,
  output logic [7:0]  byte_be_o,
  output logic [7:0]  tail_be_o
);
  logic [7:0] sel_byte, low_mask;

  assign sel_byte     = rdata_i[{src_lane_i, 3'b000} +: 8];
  assign byte_wdata_o = {8{sel_byte}};
  assign byte_be_o    = 8'h01 << dst_lane_i;
  assign low_mask     = (8'h01 << tail_e_i) - 8'h01;
  // phase 0 rewrites upper lanes of last full word, phase 1 covers the remainder
  assign tail_be_o    = tail_hi_i ? low_mask : ~low_mask;
endmodule

// File: rtl/blkcpy.sv
module blkcpy
  import blkcpy_pkg::*;
#(
  parameter int AW          = 12,
  parameter int CW          = 12,
  parameter int BURST_BYTES = 96
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] src_end_o,
  output logic [AW-1:0] dst_end_o,
  output logic [CW-1:0] left_o,
  output logic          mem_re_o,
  output logic [AW-4:0] mem_raddr_o,
  input  logic [63:0]   mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-4:0] mem_waddr_o,
  output logic [63:0]   mem_wdata_o,
  output logic [7:0]    mem_be_o
);
  localparam int WAW       = AW - 3;
  localparam int BURST_OPS = BURST_BYTES / LANES;

  state_e        state_q;
  mode_e         mode_q, mode_sel;
  logic [AW-1:0] src_q, dst_q, src_at, dst_at;
  logic [CW-1:0] len_q, idx_q, nfull;
  logic          tph_q, slot_live, burst_last;
  logic [WAW-1:0] src_w, dst_w, tail_off;
  logic [63:0]   byte_wdata;
  logic [7:0]    byte_be, tail_be;

  assign nfull      = len_q >> 3;
  assign src_w      = src_q[AW-1:3];
  assign dst_w      = dst_q[AW-1:3];
  assign src_at     = src_q + AW'(idx_q);
  assign dst_at     = dst_q + AW'(idx_q);
  assign slot_live  = idx_q < nfull;
  assign burst_last = idx_q == CW'(BURST_OPS - 1);
  assign tail_off   = tph_q ? WAW'(nfull) : WAW'(nfull) - WAW'(1);

  blkcpy_mode_sel #(.AW(AW), .CW(CW)) u_mode (
    .src_i(src_q), .dst_i(dst_q), .len_i(len_q), .mode_o(mode_sel)
  );

  blkcpy_lane u_lane (
    .rdata_i(mem_rdata_i), .src_lane_i(src_at[2:0]), .dst_lane_i(dst_at[2:0]),
    .tail_e_i(len_q[2:0]), .tail_hi_i(tph_q),
    .byte_wdata_o(byte_wdata), .byte_be_o(byte_be), .tail_be_o(tail_be)
  );

  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_FIN;
  assign left_o = (state_q == ST_IDLE || state_q == ST_FIN) ? '0 : len_q;

  always_comb begin
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_raddr_o = '0;
    mem_waddr_o = '0;
    mem_wdata_o = mem_rdata_i;
    mem_be_o    = '0;
    unique case (state_q)
      ST_BRD: begin mem_re_o = slot_live; mem_raddr_o = src_w + WAW'(idx_q); end
      ST_BWR: begin
        mem_we_o = slot_live; mem_waddr_o = dst_w + WAW'(idx_q); mem_be_o = 8'hFF;
      end
      ST_CRD: begin mem_re_o = 1'b1; mem_raddr_o = src_w + WAW'(idx_q); end
      ST_CWR: begin
        mem_we_o = 1'b1; mem_waddr_o = dst_w + WAW'(idx_q); mem_be_o = 8'hFF;
      end
      ST_TRD: begin mem_re_o = 1'b1; mem_raddr_o = src_w + tail_off; end
      ST_TWR: begin
        mem_we_o = 1'b1; mem_waddr_o = dst_w + tail_off; mem_be_o = tail_be;
      end
      ST_YRD: begin mem_re_o = 1'b1; mem_raddr_o = src_at[AW-1:3]; end
      ST_YWR: begin
        mem_we_o = 1'b1; mem_waddr_o = dst_at[AW-1:3];
        mem_wdata_o = byte_wdata; mem_be_o = byte_be;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_ZERO;
      src_q     <= '0;
      dst_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      tph_q     <= 1'b0;
      src_end_o <= '0;
      dst_end_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          src_q   <= src_i;
          dst_q   <= dst_i;
          len_q   <= len_i;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          mode_q    <= mode_sel;
          idx_q     <= '0;
          tph_q     <= 1'b0;
          src_end_o <= src_q + AW'(len_q);
          dst_end_o <= dst_q + AW'(len_q);
          unique case (mode_sel)
            MODE_ZERO: state_q <= ST_FIN;
            MODE_BYTE: state_q <= ST_YRD;
            default:   state_q <= ST_BRD;
          endcase
        end
        ST_BRD: state_q <= ST_BWR;
        ST_BWR: begin
          idx_q   <= idx_q + CW'(1);
          state_q <= burst_last ? ST_CHECK : ST_BRD;
        end
        ST_CHECK:
          if (nfull > CW'(BURST_OPS)) state_q <= ST_CRD;
          else state_q <= (len_q[2:0] != 3'd0) ? ST_TRD : ST_FIN;
        ST_CRD: state_q <= ST_CWR;
        ST_CWR:
          if (idx_q == nfull - CW'(1))
            state_q <= (len_q[2:0] != 3'd0) ? ST_TRD : ST_FIN;
          else begin
            idx_q   <= idx_q + CW'(1);
            state_q <= ST_CRD;
          end
        ST_TRD: state_q <= ST_TWR;
        ST_TWR:
          if (tph_q) state_q <= ST_FIN;
          else begin
            tph_q   <= 1'b1;
            state_q <= ST_TRD;
          end
        ST_YRD: state_q <= ST_YWR;
        ST_YWR:
          if (idx_q == len_q - CW'(1)) state_q <= ST_FIN;
          else begin
            idx_q   <= idx_q + CW'(1);
            state_q <= ST_YRD;
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: no write is ever issued for a zero-length copy
  p_zero_nowr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (len_q != '0));
  // R3: chunk mode only for aligned pointers and counts of at least 8
  p_chunk_elig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_SETUP && mode_q == MODE_CHUNK)
      |-> (src_q[2:0] == 3'd0 && dst_q[2:0] == 3'd0 && len_q >= CW'(LANES)));
  // R4: byte mode writes touch exactly one lane
  p_byte_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mode_q == MODE_BYTE) |-> $onehot(mem_be_o));
  // R5: the length check always follows a full fixed burst
  p_burst_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK) |-> ($past(state_q) == ST_BWR && idx_q == CW'(BURST_OPS)));
  // R8: every write is fed by the read issued one cycle before
  p_wr_after_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
  // R9: a start while busy leaves the captured job untouched
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(len_q) && $stable(src_q) && $stable(dst_q)));
  // R10: done is a single-cycle pulse with zero remaining count
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_left_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (left_o == '0 && busy_o));
endmodule

// File: tb/blkcpy_tb.sv
`timescale 1ns/1ps
module blkcpy_tb;
  localparam int AW = 12;
  localparam int CW = 12;
  localparam int MB = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] src_i = '0, dst_i = '0;
  logic [CW-1:0] len_i = '0;
  logic          busy_o, done_o, mem_re_o, mem_we_o;
  logic [AW-1:0] src_end_o, dst_end_o;
  logic [CW-1:0] left_o;
  logic [AW-4:0] mem_raddr_o, mem_waddr_o;
  logic [63:0]   mem_rdata_i = '0, mem_wdata_o;
  logic [7:0]    mem_be_o;

  blkcpy #(.AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
    .len_i(len_i), .busy_o(busy_o), .done_o(done_o), .src_end_o(src_end_o),
    .dst_end_o(dst_end_o), .left_o(left_o), .mem_re_o(mem_re_o),
    .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i), .mem_we_o(mem_we_o),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o)
  );

  logic [7:0] mem   [MB];
  logic [7:0] ref_m [MB];
  int checks = 0, errors = 0;
  int win_lo = 0, win_len = 0, wr_cnt = 0, last_lat = 0;
  bit win_chunk = 1'b0, prev_re = 1'b0;

  typedef struct packed { logic [AW-1:0] s; logic [AW-1:0] d; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [63:0] rd_word(input logic [AW-4:0] a);
    logic [63:0] t;
    for (int l = 0; l < 8; l++) t[l*8 +: 8] = mem[{a, 3'(l)}];
    return t;
  endfunction

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= rd_word(mem_raddr_o);
    if (mem_we_o)
      for (int l = 0; l < 8; l++)
        if (mem_be_o[l]) mem[{mem_waddr_o, 3'(l)}] <= mem_wdata_o[l*8 +: 8];
  end

  // write monitor
  always @(negedge clk) begin
    if (rst_ni && mem_we_o) begin : wm
      int bad;
      int a;
      bad = 0;
      wr_cnt++;
      for (int l = 0; l < 8; l++)
        if (mem_be_o[l]) begin
          a = {mem_waddr_o, 3'(l)};
          if (a < win_lo || a >= win_lo + win_len) bad++;
        end
      chk(bad == 0, "R1 R4 write outside buffer", bad, 0);
      if (!win_chunk) chk($countones(mem_be_o) == 1, "R4 single lane", $countones(mem_be_o), 1);
      chk(prev_re, "R8 read precedes write", int'(prev_re), 1);
    end
    prev_re = mem_re_o;
  end

  // scoreboard monitor: pop expected end pointers on done
  always @(negedge clk) begin
    if (rst_ni && done_o) begin : dm
      exp_t e;
      if (sb_q.size() == 0) chk(1'b0, "R9 R10 unexpected done", 1, 0);
      else begin
        e = sb_q.pop_front();
        chk(src_end_o == e.s, "R10 src end", int'(src_end_o), int'(e.s));
        chk(dst_end_o == e.d, "R10 dst end", int'(dst_end_o), int'(e.d));
        chk(left_o == '0, "R10 left at done", int'(left_o), 0);
      end
    end
  end

  task automatic run_copy(input int s, input int d, input int n, input bit inject,
                          input string req);
    int lat;
    int bad;
    for (int i = 0; i < n; i++) ref_m[d + i] = ref_m[s + i];
    sb_q.push_back(exp_t'{AW'(s + n), AW'(d + n)});
    win_lo = d; win_len = n; wr_cnt = 0;
    win_chunk = (s % 8 == 0) && (d % 8 == 0) && (n >= 8);
    @(negedge clk);
    src_i = AW'(s); dst_i = AW'(d); len_i = CW'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    chk(busy_o && left_o == CW'(n), "R10 busy and left after start", int'(left_o), n);
    if (inject) begin
      @(negedge clk);
      src_i = 12'hB00; dst_i = 12'hC00; len_i = 12'd16; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat += 2;
    end
    while (!done_o && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 5000) chk(1'b0, "watchdog copy hung", lat, 0);
    last_lat = lat;
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 done single cycle", int'(done_o), 0);
    bad = 0;
    for (int i = 0; i < MB; i++) if (mem[i] !== ref_m[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int l64, l8;
    for (int i = 0; i < MB; i++) begin
      mem[i]   = 8'(i * 37 + 11);
      ref_m[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && left_o == '0 && !mem_we_o && !mem_re_o,
        "R10 reset state", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    run_copy(12'h100, 12'h200, 0, 1'b0, "R1 zero count memory");
    chk(wr_cnt == 0, "R1 no writes", wr_cnt, 0);

    run_copy(12'h000, 12'h400, 64, 1'b0, "R3 chunk copy memory");
    chk(wr_cnt == 8, "R3 chunk writes", wr_cnt, 8);
    l64 = last_lat;
    run_copy(12'h080, 12'h480, 8, 1'b0, "R5 short chunk memory");
    l8 = last_lat;
    chk(l8 == l64, "R5 fixed burst latency 8 vs 64", l8, l64);
    run_copy(12'h0C0, 12'h4C0, 96, 1'b0, "R5 full burst memory");
    chk(last_lat == l64, "R5 fixed burst latency 96 vs 64", last_lat, l64);

    run_copy(12'h100, 12'h600, 200, 1'b0, "R6 beyond burst memory");
    chk(wr_cnt == 25, "R6 extra chunk writes", wr_cnt, 25);
    chk(last_lat > l64, "R6 longer than burst", last_lat, l64 + 1);

    run_copy(12'h200, 12'h700, 20, 1'b0, "R7 tail memory");
    chk(wr_cnt == 4, "R7 tail writes", wr_cnt, 4);

    run_copy(12'h300, 12'h303, 30, 1'b0, "R2 close overlap memory");
    chk(wr_cnt == 30, "R2 byte writes", wr_cnt, 30);

    run_copy(12'h351, 12'h7A4, 13, 1'b0, "R4 misaligned memory");
    chk(wr_cnt == 13, "R4 misaligned byte writes", wr_cnt, 13);

    run_copy(12'h380, 12'h7C0, 5, 1'b0, "R4 short aligned memory");
    chk(wr_cnt == 5, "R4 short byte writes", wr_cnt, 5);

    run_copy(12'h800, 12'h808, 40, 1'b0, "R3 overlap distance 8 memory");
    chk(wr_cnt == 5, "R3 overlap chunk writes", wr_cnt, 5);

    run_copy(12'hD08, 12'hD00, 33, 1'b0, "R3 R7 backward overlap memory");
    chk(wr_cnt == 6, "R7 backward tail writes", wr_cnt, 6);

    run_copy(12'h900, 12'hA00, 64, 1'b1, "R9 start while busy memory");
    chk(wr_cnt == 8, "R9 only first job writes", wr_cnt, 8);
    chk(sb_q.size() == 0, "R9 no extra result", sb_q.size(), 0);

    repeat (3) @(negedge clk);
    chk(!done_o && !busy_o, "R9 no second job", int'(busy_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule